// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small processor system through its power states. It sits beside the clock generator and drives clock-enable signals for the clock generator, the CPU, four peripheral modules and a real-time clock. It also drives a memory-mode signal that tells the memory controller to use normal refresh or self-refresh, and it reports the current state as a two-bit code. Software sets up a control register through a simple write port. The core then raises a sleep request, and the standby-select bit in the register decides whether the system enters light sleep or full standby. An interrupt or a reset brings the system back to run.

The state machine has five states. ST_RUN is normal operation. ST_SLEEP stops only the CPU clock. ST_STBY stops the clock generator, the CPU and all peripherals, and puts memory in self-refresh. ST_WAKE is a single cycle after an interrupt wake from standby: the clocks come back but the CPU is still held. ST_HWSTBY is entered when the active-low hardware standby pin is driven low, and only a power-on reset leaves it. The transitions are as follows. RUN to SLEEP or RUN to STBY happens on a sleep request. SLEEP to RUN happens on an interrupt or a reset. STBY to WAKE happens on an interrupt. STBY to RUN happens on a reset. WAKE always goes to RUN. Any state goes to HWSTBY on the synchronised pin. HWSTBY goes to RUN only on a power-on reset.

Each peripheral also has its own stop bit. This bit gates that module's clock alone and leaves the CPU running. The real-time clock runs whenever its start bit is set, in every state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (por_n low, then high): mode_o=0, cpg_en=1, cpu_en=1, mod_en=4'b1111, rtc_en=0, mem_self_ref=0. The control register reads as 0x00.
- R2: When ST_RUN sees sleep_req with control bit 7 (standby-select) at 0, the next cycle has mode_o=1 and cpu_en=0. In that cycle cpg_en=1, mod_en equals the inverse of control bits 3:0, and mem_self_ref=0.
- R3: When ST_RUN sees sleep_req with control bit 7 at 1, the next cycle has mode_o=2, cpg_en=0, cpu_en=0, mod_en=0 and mem_self_ref=1. The state holds until a wake event.
- R4: An irq in sleep returns to run on the next cycle. An irq in standby gives one wake cycle first. In the wake cycle, mode_o=2, cpg_en=1, cpu_en=0, mod_en is the inverse of the stop bits, and mem_self_ref=0. The state is run one cycle after that.
- R5: rst_req in run, sleep or standby gives the run state on the next cycle and clears the control register to 0x00, so mod_en=4'b1111 and rtc_en=0.
- R6: A write in run sets stop bits 3:0 from wr_data[3:0]. From the next cycle, mod_en[n] is 0 exactly when bit n is 1, and cpu_en stays 1.
- R7: hwstby_n passes through a two-flop synchroniser. A low level sampled at one edge gives mode_o=3 from the third edge on, with cpg_en=0, cpu_en=0, mod_en=0 and mem_self_ref=1. This takes priority over any other state.
- R8: In hardware standby, irq, rst_req, sleep_req and a return of the pin to high have no effect. Only por_n low leaves the state.
- R9: rtc_en equals control bit 4 (real-time clock start) in every state, including standby and hardware standby.
- R10: The control register holds its contents through sleep and standby. Writes made while the state is not run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous reset request; wakes the system and clears the control register |
| sleep_req | input | 1 | Sleep request from the core |
| irq | input | 1 | Interrupt request; wakes from sleep or standby |
| hwstby_n | input | 1 | Hardware standby pin, active low, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data: bit 7 standby-select, bit 4 real-time clock start, bits 3:0 module stop bits |
| cpg_en | output | 1 | Clock generator enable |
| cpu_en | output | 1 | CPU clock enable |
| mod_en | output | 4 | Per-module peripheral clock enables |
| rtc_en | output | 1 | Real-time clock enable |
| mem_self_ref | output | 1 | 1 selects memory self-refresh, 0 selects normal refresh |
| mode_o | output | 2 | Mode code: 0 run, 1 sleep, 2 standby or wake, 3 hardware standby |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- sleep and standby are entered from run on a sleep request;
- the wake cycle is always followed by run;
- hardware standby is never left while power-on reset is inactive;
- self-refresh never appears with the clock generator running;
- the register loads on a write, clears on reset and is otherwise stable.

Some behaviour only the directed scenarios can show. One example is the three-edge latency of the hardware standby pin. Others are the full enable pattern after each wake path, and that the stop and standby-select bits survive a round trip through sleep and standby. The scenarios also show that writes issued while the CPU is halted leave no trace.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_STBY   = 3'd2,
        ST_WAKE   = 3'd3,
        ST_HWSTBY = 3'd4
    } pstate_e;

    localparam logic [1:0] MODE_RUN    = 2'd0;
    localparam logic [1:0] MODE_SLEEP  = 2'd1;
    localparam logic [1:0] MODE_STBY   = 2'd2;
    localparam logic [1:0] MODE_HWSTBY = 2'd3;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg #(
    parameter int REG_W = 8,
    parameter int N_MOD = 4,
    parameter int STBY_BIT = 7,
    parameter int RTC_BIT = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             we,
    input  logic [REG_W-1:0] d,
    output logic [REG_W-1:0] q,
    output logic             stby_sel,
    output logic             rtc_start,
    output logic [N_MOD-1:0] stop
);
    localparam logic [REG_W-1:0] FIELD_MASK =
        REG_W'((1 << STBY_BIT) | (1 << RTC_BIT) | ((1 << N_MOD) - 1));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (we)
            q <= d & FIELD_MASK;
    end

    assign stby_sel  = q[STBY_BIT];
    assign rtc_start = q[RTC_BIT];
    assign stop      = q[N_MOD-1:0];

    // R6
    stop_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (we && !clr) |=> (stop == $past(d[N_MOD-1:0])));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (q == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!we && !clr) |=> $stable(q));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       hw_low,
    input  logic       sleep_req,
    input  logic       irq,
    input  logic       rst_req,
    input  logic       stby_sel,
    output pstate_e    state,
    output logic       cpg_on,
    output logic       cpu_on,
    output logic       periph_on,
    output logic       self_ref,
    output logic [1:0] mode
);
    pstate_e state_nx;

    always_comb begin
        state_nx = state;
        if (hw_low) begin
            state_nx = ST_HWSTBY;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (rst_req)
                        state_nx = ST_RUN;
                    else if (sleep_req)
                        state_nx = stby_sel ? ST_STBY : ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (rst_req || irq)
                        state_nx = ST_RUN;
                end
                ST_STBY: begin
                    if (rst_req)
                        state_nx = ST_RUN;
                    else if (irq)
                        state_nx = ST_WAKE;
                end
                ST_WAKE:   state_nx = ST_RUN;
                ST_HWSTBY: state_nx = ST_HWSTBY;
                default:   state_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state <= ST_RUN;
        else
            state <= state_nx;
    end

    always_comb begin
        cpg_on    = 1'b1;
        cpu_on    = 1'b0;
        periph_on = 1'b1;
        self_ref  = 1'b0;
        mode      = MODE_RUN;
        unique case (state)
            ST_RUN: begin
                cpu_on = 1'b1;
            end
            ST_SLEEP: begin
                mode = MODE_SLEEP;
            end
            ST_STBY: begin
                cpg_on    = 1'b0;
                periph_on = 1'b0;
                self_ref  = 1'b1;
                mode      = MODE_STBY;
            end
            ST_WAKE: begin
                mode = MODE_STBY;
            end
            ST_HWSTBY: begin
                cpg_on    = 1'b0;
                periph_on = 1'b0;
                self_ref  = 1'b1;
                mode      = MODE_HWSTBY;
            end
            default: begin
                cpu_on = 1'b1;
            end
        endcase
    end

    // R2
    enter_sleep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sleep_req && !stby_sel && !rst_req && !hw_low)
        |=> (mode == MODE_SLEEP && !cpu_on && cpg_on));

    // R3
    enter_stby_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sleep_req && stby_sel && !rst_req && !hw_low)
        |=> (mode == MODE_STBY && !cpg_on && self_ref));

    // R4
    wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_WAKE && !hw_low) |=> (state == ST_RUN));

    // R8
    hw_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MODE_HWSTBY) |=> (mode == MODE_HWSTBY));

    // R7
    hw_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        hw_low |=> (state == ST_HWSTBY));
endmodule

// File: rtl/clk_gate_map.sv
module clk_gate_map #(
    parameter int N_MOD = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cpg_on,
    input  logic             cpu_on,
    input  logic             periph_on,
    input  logic             self_ref,
    input  logic             rtc_start,
    input  logic [N_MOD-1:0] stop,
    output logic             cpg_en,
    output logic             cpu_en,
    output logic [N_MOD-1:0] mod_en,
    output logic             rtc_en,
    output logic             mem_self_ref
);
    assign cpg_en       = cpg_on;
    assign cpu_en       = cpu_on;
    assign rtc_en       = rtc_start;
    assign mem_self_ref = self_ref;

    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        assign mod_en[i] = periph_on & ~stop[i];
    end

    // R3
    selfref_no_clk_chk: assert property (@(posedge clk) disable iff (!por_n)
        mem_self_ref |-> (!cpg_en && !cpu_en && mod_en == '0));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int N_MOD = 4,
    parameter int STBY_BIT = 7,
    parameter int RTC_BIT = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_req,
    input  logic             sleep_req,
    input  logic             irq,
    input  logic             hwstby_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             cpg_en,
    output logic             cpu_en,
    output logic [N_MOD-1:0] mod_en,
    output logic             rtc_en,
    output logic             mem_self_ref,
    output logic [1:0]       mode_o
);
    logic             hw_n_sync;
    logic             hw_low;
    logic [REG_W-1:0] ctrl_q;
    logic             stby_sel;
    logic             rtc_start;
    logic [N_MOD-1:0] stop;
    pstate_e          state;
    logic             cpg_on;
    logic             cpu_on;
    logic             periph_on;
    logic             self_ref;
    logic             reg_we;
    logic             reg_clr;
    logic             unused_ctrl;

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (hwstby_n),
        .q     (hw_n_sync)
    );

    assign hw_low  = ~hw_n_sync;
    assign reg_we  = wr_en && (state == ST_RUN) && !hw_low;
    assign reg_clr = rst_req && (state != ST_HWSTBY) && !hw_low;

    pwr_ctrl_reg #(
        .REG_W(REG_W), .N_MOD(N_MOD), .STBY_BIT(STBY_BIT), .RTC_BIT(RTC_BIT)
    ) u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .clr       (reg_clr),
        .we        (reg_we),
        .d         (wr_data),
        .q         (ctrl_q),
        .stby_sel  (stby_sel),
        .rtc_start (rtc_start),
        .stop      (stop)
    );

    assign unused_ctrl = ^ctrl_q;

    pwr_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .hw_low    (hw_low),
        .sleep_req (sleep_req),
        .irq       (irq),
        .rst_req   (rst_req),
        .stby_sel  (stby_sel),
        .state     (state),
        .cpg_on    (cpg_on),
        .cpu_on    (cpu_on),
        .periph_on (periph_on),
        .self_ref  (self_ref),
        .mode      (mode_o)
    );

    clk_gate_map #(.N_MOD(N_MOD)) u_gate (
        .clk          (clk),
        .por_n        (por_n),
        .cpg_on       (cpg_on),
        .cpu_on       (cpu_on),
        .periph_on    (periph_on),
        .self_ref     (self_ref),
        .rtc_start    (rtc_start),
        .stop         (stop),
        .cpg_en       (cpg_en),
        .cpu_en       (cpu_en),
        .mod_en       (mod_en),
        .rtc_en       (rtc_en),
        .mem_self_ref (mem_self_ref)
    );
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_req = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq = 1'b0;
    logic       hwstby_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cpg_en, cpu_en, rtc_en, mem_self_ref;
    logic [3:0] mod_en;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk(clk), .por_n(por_n), .rst_req(rst_req), .sleep_req(sleep_req),
        .irq(irq), .hwstby_n(hwstby_n), .wr_en(wr_en), .wr_data(wr_data),
        .cpg_en(cpg_en), .cpu_en(cpu_en), .mod_en(mod_en), .rtc_en(rtc_en),
        .mem_self_ref(mem_self_ref), .mode_o(mode_o)
    );

    // packed observation: {mode, cpg, cpu, mod_en, rtc, selfref}
    function automatic logic [9:0] obs();
        return {mode_o, cpg_en, cpu_en, mod_en, rtc_en, mem_self_ref};
    endfunction

    // kind: 0 run, 1 sleep, 2 standby, 3 hw standby, 4 wake
    function automatic logic [9:0] expv(input int kind, input logic [3:0] stp, input logic rtc);
        case (kind)
            0:       return {2'd0, 1'b1, 1'b1, ~stp, rtc, 1'b0};
            1:       return {2'd1, 1'b1, 1'b0, ~stp, rtc, 1'b0};
            2:       return {2'd2, 1'b0, 1'b0, 4'b0000, rtc, 1'b1};
            3:       return {2'd3, 1'b0, 1'b0, 4'b0000, rtc, 1'b1};
            default: return {2'd2, 1'b1, 1'b0, ~stp, rtc, 1'b0};
        endcase
    endfunction

    task automatic chk(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = obs();
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b (mode,cpg,cpu,mod,rtc,sref) t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1; step(1); irq = 1'b0;
    endtask

    task automatic pulse_rst();
        rst_req = 1'b1; step(1); rst_req = 1'b0;
    endtask

    task automatic do_por();
        por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    endtask

    task automatic t_reset();
        do_por();
        chk("R1 reset state", expv(0, 4'b0000, 1'b0));
    endtask

    task automatic t_modstop();
        do_write(8'h05);
        chk("R6 stop bits 0101", expv(0, 4'b0101, 1'b0));
        do_write(8'h0A);
        chk("R6 stop bits 1010", expv(0, 4'b1010, 1'b0));
        do_write(8'h00);
        chk("R6 stop bits cleared", expv(0, 4'b0000, 1'b0));
    endtask

    task automatic t_sleep();
        do_write(8'h03);
        pulse_sleep();
        chk("R2 sleep entry", expv(1, 4'b0011, 1'b0));
        step(4);
        chk("R2 sleep held", expv(1, 4'b0011, 1'b0));
        do_write(8'h80);
        chk("R10 write in sleep ignored", expv(1, 4'b0011, 1'b0));
        pulse_irq();
        chk("R4 irq sleep to run", expv(0, 4'b0011, 1'b0));
        pulse_sleep();
        chk("R10 standby-select unchanged", expv(1, 4'b0011, 1'b0));
        pulse_rst();
        chk("R5 reset from sleep", expv(0, 4'b0000, 1'b0));
    endtask

    task automatic t_standby();
        do_write(8'h92);
        pulse_sleep();
        chk("R3 standby entry", expv(2, 4'b0010, 1'b1));
        step(5);
        chk("R9 rtc alive in standby", expv(2, 4'b0010, 1'b1));
        do_write(8'h00);
        pulse_irq();
        chk("R4 wake cycle", expv(4, 4'b0010, 1'b1));
        step(1);
        chk("R10 run after wake, bits held", expv(0, 4'b0010, 1'b1));
        pulse_sleep();
        chk("R10 standby-select held", expv(2, 4'b0010, 1'b1));
        pulse_rst();
        chk("R5 reset from standby clears", expv(0, 4'b0000, 1'b0));
        do_write(8'h80);
        pulse_sleep();
        chk("R9 rtc off in standby", expv(2, 4'b0000, 1'b0));
        pulse_rst();
        do_write(8'h11);
        pulse_rst();
        chk("R5 reset in run clears", expv(0, 4'b0000, 1'b0));
    endtask

    task automatic t_hwstby();
        do_write(8'h13);
        hwstby_n = 1'b0;
        step(2);
        chk("R7 pin latency not yet", expv(0, 4'b0011, 1'b1));
        step(1);
        chk("R7 hw standby entry", expv(3, 4'b0011, 1'b1));
        pulse_irq();
        pulse_rst();
        pulse_sleep();
        do_write(8'h00);
        chk("R8 hw standby ignores wake", expv(3, 4'b0011, 1'b1));
        hwstby_n = 1'b1;
        step(4);
        chk("R8 pin high does not exit", expv(3, 4'b0011, 1'b1));
        do_por();
        chk("R8 power-on reset exits", expv(0, 4'b0000, 1'b0));
        do_write(8'h80);
        pulse_sleep();
        hwstby_n = 1'b0;
        step(3);
        chk("R7 hw standby from standby", expv(3, 4'b0000, 1'b0));
        hwstby_n = 1'b1;
        do_por();
        chk("R1 reset after hw standby", expv(0, 4'b0000, 1'b0));
    endtask

    initial begin
        t_reset();
        t_modstop();
        t_sleep();
        t_standby();
        t_hwstby();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule